// File: doc/BRIEF.md
# Irreversible Test-to-User Mode Lock

This block settles, once after every power-on reset, whether the chip runs with its manufacturing test privileges or in user mode. It weighs two independent locks: a hardware fuse-state input, and a marker word held in a reserved non-volatile location that it fetches through a small read port right after reset. Either lock alone is enough to force user mode. Bridging or repairing the fuse therefore cannot bring test mode back once the marker has been written.

While test mode is granted, a test-port read path reaches the non-volatile memory. A lock command may write the lock constant into the marker location; the new state takes effect at the next reset. In user mode the test read permission is low and test-port reads return zero. Lock commands are ignored in user mode.

Top module: `test_mode_lock`

## Requirements
- R1: While reset is asserted, and in the first cycle after its release, `test_mode`, `test_rd_perm`, `mode_ready`, `mark_wr_en` and `nvm_rd_en` are low. `mark_rd_en` is high in exactly that first post-reset cycle and low from then on.
- R2: The marker word returned on `mark_rd_data` is expected in the second cycle after reset release (one-cycle read latency). `mode_ready` rises in the third cycle and stays high until the next reset.
- R3: Test mode is granted only if three conditions hold in the second post-reset cycle: `fuse_intact` is 1, `test_req` is 1, and the marker equals the erased pattern 0xFFFFFFFF.
- R4: A marker equal to the lock constant 0x5AC33CA5 forces user mode even when the fuse reads intact and test entry is requested.
- R5: Any marker other than the erased pattern or the lock constant is treated as locked and yields user mode.
- R6: Once `mode_ready` is high, the mode stays constant until the next reset, whatever `fuse_intact` and `test_req` do.
- R7: In test mode, `lock_cmd` drives `mark_wr_en` high in the same cycle, with `mark_wr_data` equal to 0x5AC33CA5. Test mode itself persists until reset.
- R8: In user mode (and before the decision), `lock_cmd` has no effect: `mark_wr_en` stays low and the stored marker is unchanged.
- R9: A test-port read (`tp_rd_en`) produces `tp_rd_valid` one cycle later. In test mode it forwards the address on `nvm_rd_addr` with `nvm_rd_en` high, and `tp_rd_data` returns the memory word. Otherwise `nvm_rd_en` stays low and `tp_rd_data` is zero.
- R10: `test_rd_perm` is high exactly while test mode is held.
- R11: After a lock has been written in test mode, the next reset yields user mode even with the fuse intact and test entry requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| fuse_intact | input | 1 | 1 when the fuse still reads as unblown |
| test_req | input | 1 | Request to enter test mode, sampled at decision |
| mark_rd_en | output | 1 | Read strobe to the marker location |
| mark_rd_data | input | MARK_W | Marker word, valid one cycle after the strobe |
| lock_cmd | input | 1 | Command to write the lock constant |
| mark_wr_en | output | 1 | Write strobe to the marker location |
| mark_wr_data | output | MARK_W | Word written to the marker location |
| tp_rd_en | input | 1 | Test-port read request |
| tp_rd_addr | input | ADDR_W | Test-port read address |
| tp_rd_valid | output | 1 | Test-port read response strobe |
| tp_rd_data | output | DATA_W | Test-port read data, zero when not permitted |
| nvm_rd_en | output | 1 | Read strobe to non-volatile memory |
| nvm_rd_addr | output | ADDR_W | Read address to non-volatile memory |
| nvm_rd_data | input | DATA_W | Memory word, valid one cycle after the strobe |
| mode_ready | output | 1 | Mode decision taken |
| test_mode | output | 1 | Test mode held |
| test_rd_perm | output | 1 | Test memory read permission |

## Verification
The bench targets a marker one bit away from the lock constant and an all-zero marker. A design that compared only against the lock constant would grant test mode on these values instead of failing safe. It toggles the fuse and request inputs after the decision: a design that kept evaluating them would drop or regain test mode mid-session. It issues lock commands in user mode and checks the stored marker, which a design with an ungated write strobe would overwrite. It also runs a lock-then-reset sequence with the fuse still intact, where a design that trusted the fuse alone would re-enter test mode. Test-port reads in user mode must return zero with no memory strobe; a leaky read path shows up as real data on the port.

// File: rtl/test_mode_lock.sv
module test_mode_lock #(
  parameter int          MARK_W      = 32,
  parameter int          ADDR_W      = 10,
  parameter int          DATA_W      = 32,
  parameter logic [31:0] LOCK_WORD   = 32'h5AC3_3CA5,
  parameter logic [31:0] ERASED_WORD = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fuse_intact,
  input  logic              test_req,
  output logic              mark_rd_en,
  input  logic [MARK_W-1:0] mark_rd_data,
  input  logic              lock_cmd,
  output logic              mark_wr_en,
  output logic [MARK_W-1:0] mark_wr_data,
  input  logic              tp_rd_en,
  input  logic [ADDR_W-1:0] tp_rd_addr,
  output logic              tp_rd_valid,
  output logic [DATA_W-1:0] tp_rd_data,
  output logic              nvm_rd_en,
  output logic [ADDR_W-1:0] nvm_rd_addr,
  input  logic [DATA_W-1:0] nvm_rd_data,
  output logic              mode_ready,
  output logic              test_mode,
  output logic              test_rd_perm
);

  localparam logic [MARK_W-1:0] LOCK_M   = LOCK_WORD[MARK_W-1:0];
  localparam logic [MARK_W-1:0] ERASED_M = ERASED_WORD[MARK_W-1:0];

  typedef enum logic [1:0] {ST_FETCH = 2'b00, ST_DECIDE = 2'b01,
                            ST_TEST = 2'b10, ST_USER = 2'b11} mode_st_t;

  mode_st_t state;
  logic     grant;
  logic     rd_grant_q;
  logic     rd_valid_q;

  // only a clean erased marker may leave the door open; anything else fails safe
  assign grant = fuse_intact & test_req & (mark_rd_data == ERASED_M);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_FETCH;
    end else begin
      case (state)
        ST_FETCH:  state <= ST_DECIDE;
        ST_DECIDE: state <= grant ? ST_TEST : ST_USER;
        default:   state <= state;
      endcase
    end
  end

  assign mark_rd_en   = (state == ST_FETCH);
  assign mode_ready   = state[1];
  assign test_mode    = (state == ST_TEST);
  assign test_rd_perm = test_mode;

  assign mark_wr_en   = lock_cmd & test_mode;
  assign mark_wr_data = LOCK_M;

  assign nvm_rd_en    = tp_rd_en & test_mode;
  assign nvm_rd_addr  = test_mode ? tp_rd_addr : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_grant_q <= 1'b0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_grant_q <= nvm_rd_en;
      rd_valid_q <= tp_rd_en;
    end
  end

  assign tp_rd_valid = rd_valid_q;
  assign tp_rd_data  = rd_grant_q ? nvm_rd_data : '0;

  assert_no_priv_before_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_ready |-> (!test_mode && !nvm_rd_en && !mark_wr_en));

  assert_ready_after_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_ready) |-> $past(mark_rd_en, 2));

  assert_grant_needs_all_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(test_mode) |-> $past(fuse_intact && test_req && (mark_rd_data == ERASED_M)));

  assert_lock_word_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_ready && mark_rd_data == LOCK_M) |=> !test_mode);

  assert_mode_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_ready && $past(mode_ready)) |-> ($stable(test_mode) && mode_ready));

  assert_write_only_in_test_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mark_wr_en |-> (mode_ready && test_rd_perm));

  assert_user_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (tp_rd_valid && !$past(test_rd_perm)) |-> (tp_rd_data == '0));

endmodule

// File: tb/tb_test_mode_lock.sv
module tb_test_mode_lock;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] LOCK   = 32'h5AC3_3CA5;
  localparam logic [31:0] ERASED = 32'hFFFF_FFFF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fuse_intact = 1'b0, test_req = 1'b0, lock_cmd = 1'b0, tp_rd_en = 1'b0;
  logic [9:0]  tp_rd_addr = '0;
  logic        mark_rd_en, mark_wr_en, tp_rd_valid, nvm_rd_en, mode_ready, test_mode, test_rd_perm;
  logic [31:0] mark_rd_data, mark_wr_data, tp_rd_data, nvm_rd_data;
  logic [9:0]  nvm_rd_addr;

  always #(CLK_PERIOD/2) clk = ~clk;

  test_mode_lock dut (
    .clk(clk), .rst_n(rst_n), .fuse_intact(fuse_intact), .test_req(test_req),
    .mark_rd_en(mark_rd_en), .mark_rd_data(mark_rd_data), .lock_cmd(lock_cmd),
    .mark_wr_en(mark_wr_en), .mark_wr_data(mark_wr_data), .tp_rd_en(tp_rd_en),
    .tp_rd_addr(tp_rd_addr), .tp_rd_valid(tp_rd_valid), .tp_rd_data(tp_rd_data),
    .nvm_rd_en(nvm_rd_en), .nvm_rd_addr(nvm_rd_addr), .nvm_rd_data(nvm_rd_data),
    .mode_ready(mode_ready), .test_mode(test_mode), .test_rd_perm(test_rd_perm));

  function automatic logic [31:0] mem_word(input logic [9:0] a);
    return (32'h3C00_0000 | {22'd0, a}) ^ ({22'd0, a} * 32'h0001_0203);
  endfunction

  // marker cell and memory models
  logic [31:0] mark_reg = ERASED, preset_val = ERASED, mark_q = '0, nvm_q = '0;
  logic        preset_go = 1'b0;
  always @(posedge clk) begin
    if (preset_go) mark_reg <= preset_val;
    else if (mark_wr_en) mark_reg <= mark_wr_data;
    if (mark_rd_en) mark_q <= mark_reg;
    if (nvm_rd_en) nvm_q <= mem_word(nvm_rd_addr);
  end
  assign mark_rd_data = mark_q;
  assign nvm_rd_data  = nvm_q;

  // reference model
  int          ecyc;
  logic        etest, eready, etp_valid;
  logic [31:0] emark, etp_data;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ecyc <= 0; etest <= 1'b0; eready <= 1'b0; etp_valid <= 1'b0; etp_data <= '0; emark <= '0;
    end else begin
      if (ecyc < 2) ecyc <= ecyc + 1;
      if (ecyc == 0) emark <= mark_reg;
      if (ecyc == 1) begin
        eready <= 1'b1;
        etest  <= fuse_intact && test_req && (emark == ERASED);
      end
      etp_valid <= tp_rd_en;
      etp_data  <= (etest && tp_rd_en) ? mem_word(tp_rd_addr) : 32'd0;
    end
  end

  int n_chk = 0, n_fail = 0, wd = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
    chk("R1", "mark_rd_en", {31'd0, mark_rd_en}, {31'd0, (ecyc == 0)});
    chk("R2", "mode_ready", {31'd0, mode_ready}, {31'd0, eready});
    chk("R3", "test_mode",  {31'd0, test_mode},  {31'd0, etest});
    chk("R10", "test_rd_perm", {31'd0, test_rd_perm}, {31'd0, etest});
    chk("R7", "mark_wr_en", {31'd0, mark_wr_en}, {31'd0, lock_cmd && etest});
    if (mark_wr_en) chk("R7", "mark_wr_data", mark_wr_data, LOCK);
    chk("R9", "nvm_rd_en", {31'd0, nvm_rd_en}, {31'd0, tp_rd_en && etest});
    chk("R9", "tp_rd_valid", {31'd0, tp_rd_valid}, {31'd0, etp_valid});
    chk("R9", "tp_rd_data", tp_rd_data, etp_data);
  endtask

  task automatic boot(input logic f, input logic r, input logic pre, input logic [31:0] mk);
    @(negedge clk);
    rst_n = 1'b0; lock_cmd = 1'b0; tp_rd_en = 1'b0;
    fuse_intact = f; test_req = r;
    preset_go = pre; preset_val = mk;
    step();
    preset_go = 1'b0;
    step();
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step();
  endtask

  task automatic reads(input int n);
    for (int i = 0; i < n; i++) begin
      tp_rd_en = (i % 3) != 2; tp_rd_addr = 10'(i * 37 + 5);
      step();
    end
    tp_rd_en = 1'b0;
    step();
  endtask

  task automatic try_lock();
    lock_cmd = 1'b1; step(); lock_cmd = 1'b0; step();
  endtask

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 50000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    // R1: state during reset
    rst_n = 1'b0;
    step();
    chk("R1", "test_mode in reset", {31'd0, test_mode}, 32'd0);

    // R3: erased marker, fuse intact, request -> test
    boot(1'b1, 1'b1, 1'b1, ERASED);
    chk("R3", "granted", {31'd0, test_mode}, 32'd1);
    reads(10);
    // R6: inputs change after decision, mode frozen
    fuse_intact = 1'b0; test_req = 1'b0;
    for (int i = 0; i < 4; i++) step();
    chk("R6", "held after fuse drop", {31'd0, test_mode}, 32'd1);
    // R7: lock written, test mode persists
    try_lock();
    chk("R7", "marker written", mark_reg, LOCK);
    chk("R7", "test persists", {31'd0, test_mode}, 32'd1);
    reads(4);

    // R11: after lock, intact fuse and request still give user mode
    boot(1'b1, 1'b1, 1'b0, 32'd0);
    chk("R11", "locked after reset", {31'd0, test_mode}, 32'd0);
    chk("R4", "lock word blocks", {31'd0, test_mode | ~mode_ready}, 32'd0);
    reads(6);
    try_lock();
    chk("R8", "marker unchanged", mark_reg, LOCK);

    // R3: fuse blown
    boot(1'b0, 1'b1, 1'b1, ERASED);
    chk("R3", "fuse blown", {31'd0, test_mode}, 32'd0);
    try_lock();
    chk("R8", "erased marker kept", mark_reg, ERASED);
    fuse_intact = 1'b1; step();
    chk("R6", "no late grant", {31'd0, test_mode}, 32'd0);
    reads(5);

    // R3: no request
    boot(1'b1, 1'b0, 1'b1, ERASED);
    chk("R3", "no request", {31'd0, test_mode}, 32'd0);

    // R5: corrupted markers
    boot(1'b1, 1'b1, 1'b1, 32'h5AC3_3CA4);
    chk("R5", "near lock word", {31'd0, test_mode}, 32'd0);
    boot(1'b1, 1'b1, 1'b1, 32'h0000_0000);
    chk("R5", "all zero", {31'd0, test_mode}, 32'd0);
    boot(1'b1, 1'b1, 1'b1, 32'hFFFF_FFFE);
    chk("R5", "near erased", {31'd0, test_mode}, 32'd0);
    reads(4);

    // R4: lock word directly
    boot(1'b1, 1'b1, 1'b1, LOCK);
    chk("R4", "lock word", {31'd0, test_mode}, 32'd0);

    // R1: reset in the middle of test mode drops privileges
    boot(1'b1, 1'b1, 1'b1, ERASED);
    chk("R3", "regranted", {31'd0, test_mode}, 32'd1);
    @(negedge clk); rst_n = 1'b0; #1;
    chk("R1", "async drop", {31'd0, test_mode | test_rd_perm}, 32'd0);
    step(); rst_n = 1'b1; step(); step(); step();

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule